// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block runs a stream of zero-address instructions against a small operand stack held in registers. Only two instructions touch memory: a load-style instruction copies a data-memory word onto the stack, and a store-style instruction writes the top entry back to memory and removes it. The arithmetic instructions name no operands. They take the two uppermost entries, discard the top one and overwrite the entry below it with the result, so each one lowers the stack depth by one.

Instructions arrive one at a time over a valid/ready handshake. Data memory is reached through a synchronous port whose read data returns one cycle after the request. An expression such as C = A + B becomes the sequence load A, load B, add, store C. This leaves the stack as deep as it was before. Two sticky flags report an attempt to grow a full stack and an attempt to consume entries that are not there. The offending instruction is dropped and processing continues.

Top module: `stack_exec_unit`

## Requirements
- R1: After reset the stack depth is 0, both error flags are clear, `instr_ready` is high, and neither memory enable is asserted.
- R2: A load instruction (opcode 2'b00) accepted with fewer than 8 entries asserts `mem_rd_en` with `mem_addr` equal to its address field in the accept cycle. `instr_ready` is low in the following cycle. The word read then appears on `tos_value`, and the depth rises by one at the end of that cycle.
- R3: A load accepted while the stack holds 8 entries sets `err_overflow`, issues no memory read, does not stall, and leaves the depth and the stack contents unchanged.
- R4: A store instruction (opcode 2'b01) accepted on a non-empty stack asserts `mem_wr_en` in the accept cycle, with `mem_addr` equal to its address field and `mem_wdata` equal to the top entry. The depth then falls by one.
- R5: A store accepted on an empty stack sets `err_underflow` and asserts no memory write.
- R6: Opcode 2'b10 replaces the second entry with second + top (modulo 2^32) and lowers the depth by one.
- R7: Opcode 2'b11 replaces the second entry with second − top (modulo 2^32) and lowers the depth by one.
- R8: An arithmetic instruction accepted with fewer than two entries sets `err_underflow` and leaves the depth and the stack contents unchanged.
- R9: Once set, each error flag stays set until reset, whatever instructions follow.
- R10: The sequence load A, load B, add, store C writes mem[A] + mem[B] to address C and leaves the depth where it started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr_op | input | 2 | Opcode: 00 load, 01 store, 10 add, 11 subtract |
| instr_addr | input | 8 | Memory address for load and store |
| mem_rd_en | output | 1 | Memory read request |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the request |
| tos_value | output | 32 | Current top-of-stack entry |
| stack_depth | output | 4 | Number of occupied entries |
| err_overflow | output | 1 | Sticky: load attempted on a full stack |
| err_underflow | output | 1 | Sticky: store or arithmetic attempted with too few entries |

## Verification
Two things can coincide. An error flag can be raised in the same cycle that an instruction is rejected. A rejected instruction can also be accepted in the very cycle the stack sits at its full or empty boundary, which is where the guard logic and the depth update meet. The bench covers this with a sweep: for every opcode, it builds each depth from 0 to 8 and then issues that opcode. In the accept cycle it judges the memory enables and the address and data, and one cycle later it judges the depth, the top entry and both flags, all against an arithmetic stack model kept in the bench.

// File: rtl/sxu_pkg.sv
package sxu_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_ADD   = 2'b10,
    OP_SUB   = 2'b11
  } sxu_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } sxu_state_e;

endpackage

// File: rtl/sxu_rst_sync.sv
module sxu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sxu_alu.sv
module sxu_alu #(
  parameter int DATA_W = 32
) (
  input  sxu_pkg::sxu_op_e    op,
  input  logic [DATA_W-1:0]   second,
  input  logic [DATA_W-1:0]   top,
  output logic [DATA_W-1:0]   result
);

  always_comb begin
    if (op == sxu_pkg::OP_SUB) begin
      result = second - top;
    end else begin
      result = second + top;
    end
  end

endmodule

// File: rtl/sxu_stack.sv
module sxu_stack #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_en,
  input  logic [DATA_W-1:0]            push_data,
  input  logic                         pop_en,
  input  logic                         fold_en,
  input  logic [DATA_W-1:0]            fold_data,
  output logic [DATA_W-1:0]            top_q,
  output logic [DATA_W-1:0]            second_q,
  output logic [$clog2(DEPTH+1)-1:0]   depth_q,
  output logic                         full,
  output logic                         empty,
  output logic                         has_two
);

  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_TWO  = CNT_W'(2);

  logic [DATA_W-1:0] slot_q   [DEPTH];
  logic [DATA_W-1:0] slot_nxt [DEPTH];
  logic [CNT_W-1:0]  depth_nxt;
  logic [IDX_W-1:0]  idx_free;
  logic [IDX_W-1:0]  idx_top;
  logic [IDX_W-1:0]  idx_second;

  assign idx_free   = IDX_W'(depth_q);
  assign idx_top    = IDX_W'(depth_q - CNT_ONE);
  assign idx_second = IDX_W'(depth_q - CNT_TWO);

  assign full    = (depth_q == CNT_FULL);
  assign empty   = (depth_q == '0);
  assign has_two = (depth_q >= CNT_TWO);

  assign top_q    = slot_q[idx_top];
  assign second_q = slot_q[idx_second];

  always_comb begin
    depth_nxt = depth_q;
    if (push_en) begin
      depth_nxt = depth_q + CNT_ONE;
    end else if (pop_en || fold_en) begin
      depth_nxt = depth_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else if (push_en || pop_en || fold_en) begin
      depth_q <= depth_nxt;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wr_en;

    always_comb begin
      wr_en       = 1'b0;
      slot_nxt[g] = slot_q[g];
      if (push_en && (idx_free == IDX_W'(g))) begin
        wr_en       = 1'b1;
        slot_nxt[g] = push_data;
      end else if (fold_en && (idx_second == IDX_W'(g))) begin
        wr_en       = 1'b1;
        slot_nxt[g] = fold_data;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        slot_q[g] <= slot_nxt[g];
      end
    end
  end

endmodule

// File: rtl/sxu_ctrl.sv
module sxu_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  sxu_pkg::sxu_op_e  instr_op,
  input  logic              full,
  input  logic              empty,
  input  logic              has_two,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              instr_ready,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic              push_en,
  output logic [DATA_W-1:0] push_data,
  output logic              pop_en,
  output logic              fold_en,
  output logic              err_overflow,
  output logic              err_underflow
);

  import sxu_pkg::*;

  sxu_state_e state_q, state_nxt;
  logic       ovf_q, ovf_nxt;
  logic       unf_q, unf_nxt;
  logic       accept;
  logic       is_load, is_store, is_alu;
  logic       ovf_hit, unf_hit;

  assign instr_ready = (state_q == ST_IDLE);
  assign accept      = instr_valid && instr_ready;

  assign is_load  = (instr_op == OP_LOAD);
  assign is_store = (instr_op == OP_STORE);
  assign is_alu   = (instr_op == OP_ADD) || (instr_op == OP_SUB);

  assign mem_rd_en = accept && is_load && !full;
  assign mem_wr_en = accept && is_store && !empty;
  assign pop_en    = mem_wr_en;
  assign fold_en   = accept && is_alu && has_two;
  assign push_en   = (state_q == ST_FILL);
  assign push_data = mem_rdata;

  assign ovf_hit = accept && is_load && full;
  assign unf_hit = accept && ((is_store && empty) || (is_alu && !has_two));

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE: if (mem_rd_en) state_nxt = ST_FILL;
      ST_FILL: state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
    ovf_nxt = ovf_q || ovf_hit;
    unf_nxt = unf_q || unf_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (ovf_hit) ovf_q <= ovf_nxt;
      if (unf_hit) unf_q <= unf_nxt;
    end
  end

  assign err_overflow  = ovf_q;
  assign err_underflow = unf_q;

endmodule

// File: rtl/stack_exec_unit.sv
module stack_exec_unit #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       instr_valid,
  output logic                       instr_ready,
  input  logic [1:0]                 instr_op,
  input  logic [ADDR_W-1:0]          instr_addr,
  output logic                       mem_rd_en,
  output logic                       mem_wr_en,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [DATA_W-1:0]          mem_wdata,
  input  logic [DATA_W-1:0]          mem_rdata,
  output logic [DATA_W-1:0]          tos_value,
  output logic [$clog2(DEPTH+1)-1:0] stack_depth,
  output logic                       err_overflow,
  output logic                       err_underflow
);

  import sxu_pkg::*;

  logic              rst_n_int;
  sxu_op_e           op;
  logic              full, empty, has_two;
  logic              push_en, pop_en, fold_en;
  logic [DATA_W-1:0] push_data, top_q, second_q, alu_res;

  assign op = sxu_op_e'(instr_op);

  sxu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sxu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .instr_valid   (instr_valid),
    .instr_op      (op),
    .full          (full),
    .empty         (empty),
    .has_two       (has_two),
    .mem_rdata     (mem_rdata),
    .instr_ready   (instr_ready),
    .mem_rd_en     (mem_rd_en),
    .mem_wr_en     (mem_wr_en),
    .push_en       (push_en),
    .push_data     (push_data),
    .pop_en        (pop_en),
    .fold_en       (fold_en),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
  );

  sxu_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (op),
    .second (second_q),
    .top    (top_q),
    .result (alu_res)
  );

  sxu_stack #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .push_en   (push_en),
    .push_data (push_data),
    .pop_en    (pop_en),
    .fold_en   (fold_en),
    .fold_data (alu_res),
    .top_q     (top_q),
    .second_q  (second_q),
    .depth_q   (stack_depth),
    .full      (full),
    .empty     (empty),
    .has_two   (has_two)
  );

  assign mem_addr  = instr_addr;
  assign mem_wdata = top_q;
  assign tos_value = top_q;

endmodule

// File: rtl/sxu_checker.sv
module sxu_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       instr_valid,
  input logic                       instr_ready,
  input logic [1:0]                 instr_op,
  input logic                       mem_rd_en,
  input logic                       mem_wr_en,
  input logic [$clog2(DEPTH+1)-1:0] stack_depth,
  input logic                       err_overflow,
  input logic                       err_underflow
);

  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic acc;
  assign acc = instr_valid && instr_ready;

  p_load_stalls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !instr_ready);

  p_fill_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_ready |=> (stack_depth == $past(stack_depth) + CNT_W'(1)));

  p_no_read_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_depth == CNT_FULL) |-> !mem_rd_en);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth <= CNT_FULL);

  p_no_write_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_depth == '0) |-> !mem_wr_en);

  p_alu_shrinks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && instr_op[1] && stack_depth >= CNT_W'(2))
      |=> (stack_depth == $past(stack_depth) - CNT_W'(1)));

  p_alu_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && instr_op[1] && stack_depth < CNT_W'(2)) |=> err_underflow);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);

  p_unf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  p_one_mem_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

endmodule

bind stack_exec_unit sxu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .instr_valid   (instr_valid),
  .instr_ready   (instr_ready),
  .instr_op      (instr_op),
  .mem_rd_en     (mem_rd_en),
  .mem_wr_en     (mem_wr_en),
  .stack_depth   (stack_depth),
  .err_overflow  (err_overflow),
  .err_underflow (err_underflow)
);

// File: tb/tb_stack_exec_unit.sv
`timescale 1ns/1ps
module tb_stack_exec_unit;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH+1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          instr_valid;
  logic          instr_ready;
  logic [1:0]    instr_op;
  logic [AW-1:0] instr_addr;
  logic          mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] tos_value;
  logic [CW-1:0] stack_depth;
  logic          err_overflow, err_underflow;

  always #2.5 clk = ~clk;

  stack_exec_unit dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_addr(instr_addr), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .tos_value(tos_value), .stack_depth(stack_depth),
    .err_overflow(err_overflow), .err_underflow(err_underflow)
  );

  logic [DW-1:0] mem [256];

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
  end

  logic [DW-1:0] ms [DEPTH];
  int  md;
  bit  m_ovf, m_unf;
  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " depth"}, DW'(stack_depth), DW'(md));
    chk({req, " overflow flag"}, DW'(err_overflow), DW'(m_ovf));
    chk({req, " underflow flag"}, DW'(err_underflow), DW'(m_unf));
    if (md > 0) chk({req, " top"}, tos_value, ms[md-1]);
  endtask

  task automatic do_reset();
    instr_valid = 1'b0;
    instr_op = 2'b00;
    instr_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    md = 0; m_ovf = 0; m_unf = 0;
  endtask

  task automatic exec(input logic [1:0] op, input logic [AW-1:0] addr, input string req);
    logic [DW-1:0] rd_val;
    logic [DW-1:0] wr_val;
    bit stall;
    stall = 0;
    rd_val = mem[addr];
    @(negedge clk);
    instr_valid = 1'b1;
    instr_op = op;
    instr_addr = addr;
    #0.5;
    chk({req, " ready at accept"}, DW'(instr_ready), 1);
    case (op)
      2'b00: begin
        if (md == DEPTH) begin
          chk({req, " no read when full"}, DW'(mem_rd_en), 0);
          m_ovf = 1;
        end else begin
          chk({req, " read enable"}, DW'(mem_rd_en), 1);
          chk({req, " read address"}, DW'(mem_addr), DW'(addr));
          stall = 1;
        end
      end
      2'b01: begin
        if (md == 0) begin
          chk({req, " no write when empty"}, DW'(mem_wr_en), 0);
          m_unf = 1;
        end else begin
          wr_val = ms[md-1];
          chk({req, " write enable"}, DW'(mem_wr_en), 1);
          chk({req, " write address"}, DW'(mem_addr), DW'(addr));
          chk({req, " write data"}, mem_wdata, wr_val);
          md--;
        end
      end
      default: begin
        chk({req, " no memory access"}, DW'(mem_rd_en | mem_wr_en), 0);
        if (md < 2) begin
          m_unf = 1;
        end else begin
          ms[md-2] = (op == 2'b10) ? ms[md-2] + ms[md-1] : ms[md-2] - ms[md-1];
          md--;
        end
      end
    endcase
    @(posedge clk);
    @(negedge clk);
    instr_valid = 1'b0;
    if (stall) begin
      chk({req, " ready low during read"}, DW'(instr_ready), 0);
      @(negedge clk);
      ms[md] = rd_val;
      md++;
    end
    chk({req, " ready after"}, DW'(instr_ready), 1);
    if (op == 2'b01 && !m_unf) chk({req, " memory content"}, mem[addr], wr_val);
    chk_state(req);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h0F1E_2D3C;
    mem[250] = 32'h0;
    mem[251] = 32'hFFFF_FFFF;
    mem_rdata = '0;

    do_reset();
    chk("R1 depth", DW'(stack_depth), 0);
    chk("R1 overflow", DW'(err_overflow), 0);
    chk("R1 underflow", DW'(err_underflow), 0);
    chk("R1 ready", DW'(instr_ready), 1);
    chk("R1 enables", DW'(mem_rd_en | mem_wr_en), 0);

    for (int i = 0; i < DEPTH; i++) exec(2'b00, AW'(i * 3 + 1), "R2 load");
    exec(2'b00, 8'd40, "R3 load full");
    exec(2'b00, 8'd41, "R9 overflow stays");
    for (int i = 0; i < DEPTH - 1; i++) exec((i % 2 == 0) ? 2'b10 : 2'b11, '0, "R6 R7 alu chain");
    exec(2'b10, '0, "R8 add one entry");
    exec(2'b11, '0, "R8 sub one entry");
    exec(2'b01, 8'd200, "R4 store");
    exec(2'b01, 8'd201, "R5 store empty");
    exec(2'b00, 8'd7, "R9 flags after load");

    do_reset();
    chk_state("R1 flags cleared");
    exec(2'b00, 8'd10, "R10 load A");
    exec(2'b00, 8'd11, "R10 load B");
    exec(2'b10, '0, "R10 add");
    exec(2'b01, 8'd100, "R10 store C");
    chk("R10 C value", mem[100], mem[10] + mem[11]);
    chk("R10 depth", DW'(stack_depth), 0);

    exec(2'b00, 8'd250, "R7 wrap load");
    exec(2'b00, 8'd251, "R7 wrap load");
    exec(2'b11, '0, "R7 sub wrap");
    chk("R7 zero minus ones", tos_value, 32'h1);
    exec(2'b00, 8'd251, "R6 wrap load");
    exec(2'b00, 8'd251, "R6 wrap load");
    exec(2'b10, '0, "R6 add wrap");
    chk("R6 ones plus ones", tos_value, 32'hFFFF_FFFE);

    for (int op = 0; op < 4; op++) begin
      for (int d = 0; d <= DEPTH; d++) begin
        do_reset();
        for (int k = 0; k < d; k++) exec(2'b00, AW'(20 + k * 5 + op), "R2 sweep fill");
        exec(2'(op), AW'(150 + d), (op == 0) ? "R3 sweep load" : (op == 1) ? "R5 sweep store" : "R8 sweep alu");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule